// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block guards a 36-bit data port that is divided into four 9-bit byte lanes. In each lane the top bit carries parity for the eight bits beneath it. Incoming words on the port are checked lane by lane, and an active-low error flag drops whenever any lane carries the wrong parity. Outgoing mailbox read data can have its lane parity bits rebuilt, so the word that leaves the port always carries correct parity.

One select input chooses even or odd parity, and that choice applies to both checking and generation. Only one set of per-lane parity trees exists. When a mailbox read with generation is set up, those trees are taken over to build parity for the read data. The check result is then meaningless, so the error flag is held inactive. The block has no state: both outputs follow the current inputs within the same cycle.

Top module: `bytelane_parity`

## Requirements
- R1: Lanes occupy bits [8:0], [17:9], [26:18] and [35:27]. Bit 8 of each lane (bits 8, 17, 26, 35) is the lane's parity bit, and a single flipped bit anywhere in any lane is detected.
- R2: With `odd_sel`=0 (even parity), a word in which every 9-bit lane holds an even number of ones keeps `perr_n` high.
- R3: With `odd_sel`=1 (odd parity), a word in which every 9-bit lane holds an odd number of ones keeps `perr_n` high.
- R4: `perr_n` is low when one or more lanes of `in_bus` fail the selected parity, regardless of how many lanes fail, unless R7 applies.
- R5: During a generating mailbox read with `odd_sel`=0, each lane MSB of `rd_out` equals the XOR of that lane's eight low bits of `rd_src`. The low eight bits pass through unchanged.
- R6: During a generating mailbox read with `odd_sel`=1, each lane MSB of `rd_out` is the inverse of that XOR, so every lane holds an odd number of ones.
- R7: A generating mailbox read is `cs_n`=0, `port_en`=1, `wr_rd`=0 (read), `mbox_sel`=1 and `gen_en`=1. While it is set up, `perr_n` is forced high whatever `in_bus` carries.
- R8: If any one of the five qualifiers in R7 is not in its active state, `rd_out` equals `rd_src` exactly, and `perr_n` reflects the check of `in_bus`.
- R9: Both outputs are combinational. They settle within the same cycle as an input change and hold no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_bus | input | 36 | Incoming port word to be checked |
| rd_src | input | 36 | Mailbox read data before parity adjustment |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| gen_en | input | 1 | Parity generation enable |
| cs_n | input | 1 | Port select, active low |
| port_en | input | 1 | Port enable, active high |
| wr_rd | input | 1 | 1 = write, 0 = read |
| mbox_sel | input | 1 | Selects the mailbox instead of the queue |
| perr_n | output | 1 | Parity error flag, active low |
| rd_out | output | 36 | Read data with regenerated lane parity |

## Verification
Immediate assertions check the following each time the inputs change:
- the flag is held high during a generating mailbox read;
- every lane of the generated read word has the selected parity;
- low data bits are never altered;
- read data passes through untouched outside a generating read;
- outside a generating read, the flag agrees with a lane-by-lane count of `in_bus`.

Some behaviour can only be shown by the bench's scenarios:
- a single flipped bit is caught in every one of the 36 positions in both senses;
- those same errors are masked once the read qualifiers line up;
- only the single combination of all five qualifiers triggers generation.

// File: rtl/bl_parity_pkg.sv
package bl_parity_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int BUS_W  = LANES * LANE_W;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_sense_e;

    typedef struct packed {
        logic cs_n;
        logic port_en;
        logic wr_rd;
        logic mbox_sel;
        logic gen_en;
    } mbox_qual_t;

    // True only when a mailbox read with parity generation is set up.
    function automatic logic is_gen_read(mbox_qual_t q);
        return !q.cs_n && q.port_en && !q.wr_rd && q.mbox_sel && q.gen_en;
    endfunction

endpackage

// File: rtl/bl_parity_tree.sv
module bl_parity_tree #(
    parameter int LANES  = bl_parity_pkg::LANES,
    parameter int LANE_W = bl_parity_pkg::LANE_W,
    localparam int BUS_W = LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic [BUS_W-1:0] word,
    output logic [LANES-1:0] lane_xor
);
    // One XOR tree per lane over the data bits (parity bit excluded).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_xor[i] = ^word[i*LANE_W +: DATA_W];
    end
endmodule

// File: rtl/bl_parity_check.sv
module bl_parity_check #(
    parameter int LANES  = bl_parity_pkg::LANES,
    parameter int LANE_W = bl_parity_pkg::LANE_W,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic [BUS_W-1:0]      word,
    input  logic [LANES-1:0]      lane_xor,
    input  bl_parity_pkg::par_sense_e sense,
    input  logic                  force_ok,
    output logic                  perr_n
);
    logic [LANES-1:0] lane_fail;

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // Nine-bit parity must equal the sense bit: 0 for even, 1 for odd.
        assign lane_fail[i] = (lane_xor[i] ^ word[i*LANE_W + LANE_W - 1]) != sense;
    end

    assign perr_n = force_ok | ~(|lane_fail);
endmodule

// File: rtl/bl_parity_gen.sv
module bl_parity_gen #(
    parameter int LANES  = bl_parity_pkg::LANES,
    parameter int LANE_W = bl_parity_pkg::LANE_W,
    localparam int BUS_W = LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic [BUS_W-1:0]      rd_src,
    input  logic [LANES-1:0]      lane_xor,
    input  bl_parity_pkg::par_sense_e sense,
    input  logic                  gen_on,
    output logic [BUS_W-1:0]      rd_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_gen
        assign rd_out[i*LANE_W +: DATA_W] = rd_src[i*LANE_W +: DATA_W];
        assign rd_out[i*LANE_W + DATA_W]  = gen_on ? (lane_xor[i] ^ sense)
                                                   : rd_src[i*LANE_W + DATA_W];
    end
endmodule

// File: rtl/bytelane_parity.sv
module bytelane_parity
    import bl_parity_pkg::*;
(
    input  logic [35:0] in_bus,
    input  logic [35:0] rd_src,
    input  logic        odd_sel,
    input  logic        gen_en,
    input  logic        cs_n,
    input  logic        port_en,
    input  logic        wr_rd,
    input  logic        mbox_sel,
    output logic        perr_n,
    output logic [35:0] rd_out
);
    localparam int DATA_W = LANE_W - 1;

    mbox_qual_t       qual;
    par_sense_e       sense;
    logic             gen_rd;
    logic [BUS_W-1:0] tree_in;
    logic [LANES-1:0] lane_xor;

    assign qual   = '{cs_n: cs_n, port_en: port_en, wr_rd: wr_rd,
                      mbox_sel: mbox_sel, gen_en: gen_en};
    assign sense  = par_sense_e'(odd_sel);
    assign gen_rd = is_gen_read(qual);

    // The single set of trees is steered to read data during a generating read.
    assign tree_in = gen_rd ? rd_src : in_bus;

    bl_parity_tree #(.LANES(LANES), .LANE_W(LANE_W)) u_tree (
        .word     (tree_in),
        .lane_xor (lane_xor)
    );

    bl_parity_check #(.LANES(LANES), .LANE_W(LANE_W)) u_check (
        .word     (in_bus),
        .lane_xor (lane_xor),
        .sense    (sense),
        .force_ok (gen_rd),
        .perr_n   (perr_n)
    );

    bl_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
        .rd_src   (rd_src),
        .lane_xor (lane_xor),
        .sense    (sense),
        .gen_on   (gen_rd),
        .rd_out   (rd_out)
    );

    // Assertions guarding the combinational datapath.
    always_comb begin
        if (!$isunknown({in_bus, rd_src, odd_sel, gen_en, cs_n, port_en, wr_rd, mbox_sel})) begin
            logic all_ok;
            all_ok = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                if (($countones(in_bus[i*LANE_W +: LANE_W]) % 2) != int'(odd_sel))
                    all_ok = 1'b0;
            end
            if (gen_rd) begin
                assert_masked_flag_R7: assert (perr_n == 1'b1)
                    else $error("flag not forced high during generating read");
                for (int i = 0; i < LANES; i++) begin
                    assert_gen_lane_sense_R6: assert (($countones(rd_out[i*LANE_W +: LANE_W]) % 2) == int'(odd_sel))
                        else $error("generated lane %0d has wrong parity", i);
                end
            end else begin
                assert_passthru_R8: assert (rd_out == rd_src)
                    else $error("read data altered outside generating read");
                assert_check_flag_R4: assert (perr_n == all_ok)
                    else $error("flag disagrees with lane count");
            end
            for (int i = 0; i < LANES; i++) begin
                assert_low_bits_kept_R5: assert (rd_out[i*LANE_W +: DATA_W] == rd_src[i*LANE_W +: DATA_W])
                    else $error("data bits of lane %0d changed", i);
            end
        end
    end
endmodule

// File: tb/bytelane_parity_test.sv
module bytelane_parity_test;
    logic        clk = 1'b0;
    logic [35:0] in_bus = '0, rd_src = '0;
    logic        odd_sel = 1'b0, gen_en = 1'b0, cs_n = 1'b1, port_en = 1'b0;
    logic        wr_rd = 1'b1, mbox_sel = 1'b0;
    logic        perr_n;
    logic [35:0] rd_out;
    int          n_cmp = 0, n_bad = 0;
    logic [35:0] lfsr = 36'h9_A5C3_1E77;
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bytelane_parity uut (
        .in_bus(in_bus), .rd_src(rd_src), .odd_sel(odd_sel), .gen_en(gen_en),
        .cs_n(cs_n), .port_en(port_en), .wr_rd(wr_rd), .mbox_sel(mbox_sel),
        .perr_n(perr_n), .rd_out(rd_out)
    );

    function automatic logic [35:0] next_rand(logic [35:0] s);
        return {s[34:0], s[35] ^ s[24]};
    endfunction

    // Build a word whose lanes each carry the requested parity sense.
    function automatic logic [35:0] fix_parity(logic [35:0] w, logic odd);
        logic [35:0] r = w;
        for (int l = 0; l < 4; l++) begin
            int c = $countones(w[l*9 +: 8]);
            r[l*9 + 8] = ((c % 2) == 1) ^ odd;
        end
        return r;
    endfunction

    function automatic logic exp_flag(logic [35:0] w, logic odd);
        for (int l = 0; l < 4; l++)
            if (($countones(w[l*9 +: 9]) % 2) != int'(odd)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic set_qual(logic [4:0] q);
        {cs_n, port_en, wr_rd, mbox_sel, gen_en} = q;
    endtask

    localparam logic [4:0] GEN_RD = 5'b0_1_0_1_1;

    initial begin
        // Reset-time state: idle qualifiers, zero buses, even parity.
        settle();
        chk("R2 idle zero word", {35'd0, perr_n}, 36'd1);
        chk("R8 idle passthru", rd_out, 36'd0);

        // Single-bit error sweep over every bit position, both senses.
        for (int s = 0; s < 2; s++) begin
            odd_sel = s[0];
            for (int b = 0; b < 36; b++) begin
                logic [35:0] good;
                lfsr = next_rand(lfsr);
                good = fix_parity(lfsr, s[0]);
                set_qual(5'b1_0_1_0_0);
                in_bus = good;
                settle();
                chk(s ? "R3 clean odd" : "R2 clean even", {35'd0, perr_n}, 36'd1);
                in_bus = good ^ (36'd1 << b);
                settle();
                chk("R1 single-bit error", {35'd0, perr_n}, 36'd0);
                // Mask with a generating read; check generated data.
                rd_src = lfsr ^ 36'h5_5AA5_F00F;
                set_qual(GEN_RD);
                settle();
                chk("R7 error masked", {35'd0, perr_n}, 36'd1);
                chk(s ? "R6 odd generation" : "R5 even generation", rd_out,
                    fix_parity(rd_src, s[0]));
            end
        end

        // Multi-lane failures and random words against computed flag.
        set_qual(5'b1_0_1_0_0);
        for (int k = 0; k < 200; k++) begin
            lfsr = next_rand(lfsr);
            in_bus = lfsr;
            odd_sel = lfsr[3];
            settle();
            chk("R4 random word flag", {35'd0, perr_n}, {35'd0, exp_flag(lfsr, lfsr[3])});
        end
        odd_sel = 1'b0;
        in_bus = fix_parity(36'h1_2345_6789, 1'b0) ^ 36'h8_0402_0100;
        settle();
        chk("R4 all four lanes failing", {35'd0, perr_n}, 36'd0);

        // Qualifier sweep: only the full combination generates and masks.
        for (int q = 0; q < 32; q++) begin
            lfsr = next_rand(lfsr);
            rd_src = lfsr;
            in_bus = fix_parity(lfsr, 1'b1) ^ 36'd1;
            odd_sel = 1'b1;
            set_qual(q[4:0]);
            settle();
            if (q[4:0] == GEN_RD) begin
                chk("R7 full qualifiers mask", {35'd0, perr_n}, 36'd1);
                chk("R6 full qualifiers generate", rd_out, fix_parity(lfsr, 1'b1));
            end else begin
                chk("R8 partial qualifiers passthru", rd_out, lfsr);
                chk("R8 partial qualifiers check", {35'd0, perr_n}, 36'd0);
            end
        end

        // No memory: the flag follows the inputs back and forth.
        set_qual(5'b1_0_1_0_0);
        odd_sel = 1'b0;
        in_bus = 36'd1;
        settle();
        chk("R9 error then", {35'd0, perr_n}, 36'd0);
        in_bus = 36'd0;
        settle();
        chk("R9 clean now", {35'd0, perr_n}, 36'd1);
        odd_sel = 1'b1;
        settle();
        chk("R9 sense flip", {35'd0, perr_n}, 36'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule